// File: doc/BRIEF.md
# Raster Line Fetcher with Shared Memory Bus Arbiter

This block loads one raster line of pixel bytes from an external frame buffer into on-chip line storage of up to 256 bytes, reading one byte per clock in an unbroken burst. The same external memory bus, with a 17-bit address, 8-bit data and active-low write and output strobes, also serves a CPU. The block arbitrates between the two and steers address, data and strobes to whichever one owns the bus.

A line is requested by pulsing `line_go` with a frame base address, a line index and a byte count. The burst starts at base + index × count. The line storage has a second, independent read port for the raster side. `line_ready` rises once every byte of the line has been stored, and the raster side may start draining at once.

CPU accesses use a request/wait handshake and take one bus cycle each. A line burst outranks the CPU, but it never cuts off a CPU access that is already on the bus.

Top module: `line_fetch_arbiter`

## Requirements
- R1: After reset `line_ready`, `cpu_done` and `mem_drive` are 0, `mem_we_n` and `mem_oe_n` are 1, and `cpu_wait` is 0 while `cpu_req` is 0.
- R2: A burst reads `line_len` bytes at consecutive addresses, one per clock. The first address is `frame_base + line_idx*line_len`, truncated to 17 bits so it wraps modulo 2^17. During each burst cycle `mem_oe_n`=0 and `mem_we_n`=1. The byte read in burst cycle i is stored at line index i.
- R3: When `line_go` is sampled high at clock edge k, `line_ready` is 0 after edge k. The burst occupies the `line_len` cycles that follow edge k+1. `line_ready` is 1 after edge k+1+`line_len`.
- R4: A `line_go` whose `line_len` is 0 or greater than 256 is ignored: there is no bus activity and `line_ready` is unchanged.
- R5: A `line_go` that arrives while a burst is pending or running is ignored, and the running line completes with its original address, length and timing.
- R6: A CPU write (`cpu_we`=1) occupies one bus cycle with `mem_we_n`=0, `mem_oe_n`=1, `mem_drive`=1, `mem_addr`=`cpu_addr` and `mem_dout`=`cpu_wdata`.
- R7: A CPU read (`cpu_we`=0) occupies one bus cycle with `mem_oe_n`=0, `mem_we_n`=1 and `mem_drive`=0. `cpu_rdata` holds the byte read while `cpu_done` is high.
- R8: A burst has priority. A CPU request made in the same cycle as an accepted `line_go`, or while a burst is pending or running, sees `cpu_wait`=1 until the burst ends. For a length L, the request is accepted at the edge k+L+2.
- R9: A CPU access already on the bus when `line_go` arrives completes first, with its strobes unchanged. The burst then starts, with the same R3 timing counted from the edge where `line_go` was sampled.
- R10: The raster port returns the byte at `rd_addr` one clock after `rd_addr` is presented. The byte written by the final burst cycle is readable straight after `line_ready` rises.
- R11: A CPU request is accepted at the first edge where `cpu_wait` is 0. The bus cycle is the following clock, and `cpu_done` is high for exactly the one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_go | input | 1 | Request a line burst (one-cycle pulse) |
| frame_base | input | 17 | Frame buffer base address |
| line_idx | input | 9 | Raster line index |
| line_len | input | 9 | Bytes per line, 1..256 |
| line_ready | output | 1 | Line fully stored |
| rd_addr | input | 8 | Raster read index |
| rd_data | output | 8 | Raster read byte, one clock latency |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 17 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_wait | output | 1 | Request not accepted this cycle |
| cpu_done | output | 1 | Access completed (one-cycle pulse) |
| cpu_rdata | output | 8 | Read result |
| mem_addr | output | 17 | External address bus |
| mem_dout | output | 8 | External write data |
| mem_drive | output | 1 | Data bus driven by this block |
| mem_din | input | 8 | External read data |
| mem_we_n | output | 1 | Write enable, low = write |
| mem_oe_n | output | 1 | Output enable, low = read |

## Verification
Two collisions are forced on purpose. In the first, a CPU read request and a line request are raised on the same clock, so the burst must win. The bench counts the wait cycles and expects exactly L+2, then checks the read data. In the second, the line request lands in the very clock in which a CPU write is on the bus. The bench checks that the write strobes are unchanged in that clock, that `line_ready` arrives on the normal schedule, and that the written byte shows up inside the fetched line, which proves the write finished before the burst read that address.

// File: rtl/line_fetch_arbiter.sv
module line_fetch_arbiter #(
  parameter int AW    = 17,
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int IW    = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_go,
  input  logic [AW-1:0]              frame_base,
  input  logic [IW-1:0]              line_idx,
  input  logic [$clog2(DEPTH):0]     line_len,
  output logic                       line_ready,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [DW-1:0]              rd_data,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [AW-1:0]              cpu_addr,
  input  logic [DW-1:0]              cpu_wdata,
  output logic                       cpu_wait,
  output logic                       cpu_done,
  output logic [DW-1:0]              cpu_rdata,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_dout,
  output logic                       mem_drive,
  input  logic [DW-1:0]              mem_din,
  output logic                       mem_we_n,
  output logic                       mem_oe_n
);
  localparam int CW = $clog2(DEPTH);
  localparam int LW = CW + 1;
  localparam int PW = IW + LW;

  typedef enum logic [1:0] {S_IDLE, S_CPU, S_BURST} st_t;

  st_t            state;
  logic           pend;
  logic [AW-1:0]  start_r;
  logic [LW-1:0]  len_r, cnt;
  logic           ca_we;
  logic [AW-1:0]  ca_addr;
  logic [DW-1:0]  ca_wdata;
  logic [DW-1:0]  lbuf [DEPTH];

  logic [PW-1:0]  prod;
  logic [AW-1:0]  start_calc;
  logic           len_ok, go_take, accept, last;

  assign prod       = PW'(line_idx) * PW'(line_len);
  assign start_calc = frame_base + AW'(prod);
  assign len_ok     = (line_len != '0) && (line_len <= LW'(DEPTH));
  assign go_take    = line_go && len_ok && !pend && (state != S_BURST);
  assign accept     = cpu_req && (state == S_IDLE) && !pend && !go_take;
  assign cpu_wait   = cpu_req && !accept;
  assign last       = (cnt == len_r - LW'(1));

  assign mem_drive = (state == S_CPU) && ca_we;
  assign mem_we_n  = !mem_drive;
  assign mem_oe_n  = !((state == S_BURST) || ((state == S_CPU) && !ca_we));
  assign mem_dout  = mem_drive ? ca_wdata : '0;
  assign mem_addr  = (state == S_BURST) ? start_r + AW'(cnt) :
                     (state == S_CPU)   ? ca_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      start_r    <= '0;
      len_r      <= '0;
      cnt        <= '0;
      ca_we      <= 1'b0;
      ca_addr    <= '0;
      ca_wdata   <= '0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      line_ready <= 1'b0;
    end else begin
      cpu_done <= (state == S_CPU);
      if (go_take) begin
        pend       <= 1'b1;
        start_r    <= start_calc;
        len_r      <= line_len;
        line_ready <= 1'b0;
      end
      case (state)
        S_IDLE:
          if (pend) begin
            state <= S_BURST;
            pend  <= 1'b0;
            cnt   <= '0;
          end else if (accept) begin
            state    <= S_CPU;
            ca_we    <= cpu_we;
            ca_addr  <= cpu_addr;
            ca_wdata <= cpu_wdata;
          end
        S_CPU: begin
          if (!ca_we) cpu_rdata <= mem_din;
          state <= S_IDLE;
        end
        S_BURST: begin
          cnt <= cnt + LW'(1);
          if (last) begin
            state      <= S_IDLE;
            line_ready <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_BURST) lbuf[cnt[CW-1:0]] <= mem_din;
    rd_data <= lbuf[rd_addr];
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  assert_drive_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> (!mem_we_n && mem_oe_n));
  assert_burst_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BURST && $past(state == S_BURST)) |-> mem_addr == AW'($past(mem_addr) + AW'(1)));
  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_ready) |-> $past(state == S_BURST));
  assert_burst_blocks_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BURST && cpu_req) |-> cpu_wait);
  assert_cpu_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CPU) |=> (state == S_IDLE && cpu_done));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

// File: tb/tb_line_fetch_arbiter.sv
module tb_line_fetch_arbiter;
  logic clk = 0, rst_n = 0;
  logic line_go = 0;
  logic [16:0] frame_base = 0;
  logic [8:0] line_idx = 0, line_len = 0;
  logic line_ready;
  logic [7:0] rd_addr = 0, rd_data;
  logic cpu_req = 0, cpu_we = 0;
  logic [16:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic cpu_wait, cpu_done;
  logic [7:0] cpu_rdata;
  logic [16:0] mem_addr;
  logic [7:0] mem_dout, mem_din;
  logic mem_drive, mem_we_n, mem_oe_n;

  logic [7:0] mem [4096];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  line_fetch_arbiter dut (.*);

  assign mem_din = mem[mem_addr[11:0]];
  always @(posedge clk) if (!mem_we_n) mem[mem_addr[11:0]] <= mem_dout;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_line(input logic [16:0] b, input logic [8:0] i, input logic [8:0] l);
    @(negedge clk);
    frame_base = b; line_idx = i; line_len = l; line_go = 1;
    @(negedge clk);
    line_go = 0;
  endtask

  // pipelined readback: rd_addr set each negedge, data checked one clock later (R10)
  task automatic verify_buf(input string req, input logic [16:0] s, input int l);
    int bad = 0;
    @(negedge clk); rd_addr = 0;
    for (int j = 0; j < l; j++) begin
      @(negedge clk);
      if (rd_data != mem[12'(s + 17'(j))]) bad++;
      rd_addr = 8'(j + 1);
    end
    check(req, "line contents / read latency mismatches", bad, 0);
  endtask

  task automatic cpu_op(input bit we, input logic [16:0] a, input logic [7:0] wd,
                        output logic [7:0] rdat, output int waits);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; waits = 0;
    #1;
    while (cpu_wait) begin
      @(negedge clk); waits++; #1;
    end
    @(negedge clk);
    cpu_req = 0;
    if (we) begin
      check("R6", "write strobes {we_n,oe_n,drive}", {mem_we_n, mem_oe_n, mem_drive}, 3'b011);
      check("R6", "write addr", mem_addr, a);
      check("R6", "write data", mem_dout, wd);
    end else begin
      check("R7", "read strobes {we_n,oe_n,drive}", {mem_we_n, mem_oe_n, mem_drive}, 3'b100);
      check("R7", "read addr", mem_addr, a);
    end
    @(negedge clk);
    check("R11", "cpu_done after bus cycle", cpu_done, 1);
    rdat = cpu_rdata;
    @(negedge clk);
    check("R11", "cpu_done single pulse", cpu_done, 0);
  endtask

  task automatic t_reset;
    check("R1", "line_ready", line_ready, 0);
    check("R1", "cpu_done", cpu_done, 0);
    check("R1", "cpu_wait", cpu_wait, 0);
    check("R1", "strobes {we_n,oe_n,drive}", {mem_we_n, mem_oe_n, mem_drive}, 3'b110);
  endtask

  task automatic t_burst(input string req, input logic [16:0] b, input logic [8:0] i,
                         input logic [8:0] l, input bit disturb);
    logic [16:0] s = 17'(b + 17'(i) * 17'(l));
    int bad = 0;
    start_line(b, i, l);
    check("R3", "ready cleared after go", line_ready, 0);
    for (int j = 0; j < l; j++) begin
      @(negedge clk);
      if (mem_oe_n || !mem_we_n || mem_addr != 17'(s + 17'(j)) || line_ready) bad++;
      if (disturb && j == 3) begin
        frame_base = 17'h00333; line_idx = 1; line_len = 9; line_go = 1;
      end else line_go = 0;
    end
    check(req, "burst address/strobe mismatches", bad, 0);
    @(negedge clk);
    check("R3", "ready after last burst byte", line_ready, 1);
    rd_addr = 8'(l - 1);
    @(negedge clk);
    check("R10", "last byte readable right after ready", rd_data, mem[12'(s + 17'(l) - 1)]);
    check("R5", "no further bus activity", mem_oe_n, 1);
    verify_buf(req, s, l);
  endtask

  task automatic t_bad_len(input logic [8:0] l);
    int act = 0;
    start_line(17'h00010, 2, l);
    for (int j = 0; j < 6; j++) begin
      if (!mem_oe_n || !mem_we_n || !line_ready) act++;
      @(negedge clk);
    end
    check("R4", $sformatf("bad length %0d ignored", l), act, 0);
  endtask

  task automatic t_rw;
    logic [7:0] r; int w;
    cpu_op(1, 17'h00ABC, 8'h5A, r, w);
    check("R11", "no wait when idle", w, 0);
    check("R6", "memory updated", mem[12'hABC], 8'h5A);
    cpu_op(0, 17'h00ABC, 8'h00, r, w);
    check("R7", "read data", r, 8'h5A);
    cpu_op(0, 17'h00123, 8'h00, r, w);
    check("R7", "read data other addr", r, mem[12'h123]);
  endtask

  task automatic t_priority;
    logic [7:0] r; int w; int l = 20;
    fork
      start_line(17'h00200, 0, 9'(l));
      cpu_op(0, 17'h00777, 8'h00, r, w);
    join
    check("R8", "cpu wait cycles behind burst", w, l + 2);
    check("R8", "cpu read data after burst", r, mem[12'h777]);
    check("R8", "line ready before cpu served", line_ready, 1);
    verify_buf("R8", 17'h00200, l);
  endtask

  task automatic t_cpu_first;
    logic [7:0] r; int w; int n = 0; int l = 16;
    fork
      cpu_op(1, 17'h00505, 8'hC3, r, w);
      begin
        @(negedge clk);
        start_line(17'h00500, 0, 9'(l));
        while (!line_ready && n < 100) begin @(negedge clk); n++; end
      end
    join
    check("R9", "ready delay counted from go", n, l + 1);
    verify_buf("R9", 17'h00500, l);
    rd_addr = 5;
    @(negedge clk); @(negedge clk);
    check("R9", "cpu write landed before burst read", rd_data, 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 4));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_burst("R2", 17'h00040, 3, 9'd12, 0);
    t_burst("R2", 17'h00100, 3, 9'd256, 0);
    t_burst("R2", 17'h1FFF0, 0, 9'd32, 0);
    t_bad_len(9'd0);
    t_bad_len(9'd300);
    t_burst("R5", 17'h00800, 2, 9'd40, 1);
    t_rw();
    t_priority();
    t_cpu_first();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule